// File: doc/BRIEF.md
# Progressive Composite Video Raster Timer

This block sets the raster timing for a pattern generator that runs at the pixel rate of 3.2768 MHz. It counts a horizontal position from 1 to 210 inside each line, which gives a line period of about 64.08 µs. It also counts lines from 1 to 312 inside each field. Both counts go to the pattern logic, which uses them to address or draw each picture element.

From the same counts the block makes three outputs: an active-low composite sync, a blanking flag and a one-clock end-of-field pulse. The field is progressive, with no interlace. Field sync is simplified: sync stays low for whole lines and has no serrations or equalising pulses. A field lasts exactly 65,520 clocks and then returns to position 1 of line 1.

All outputs come from registers. Sync, blanking and the end-of-field pulse therefore always describe the position shown on the count outputs in the same cycle.

Top module: `cvid_timing`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is position 1, line 1, `csync_n` 0, `blank` 1 and `eof` 0.
- R2: `pos` advances by one per clock from 1 to 210, and after 210 it returns to 1.
- R3: `line` holds its value within a line. It advances by one on the clock after position 210, and after line 312 it returns to 1. A field therefore spans exactly 65,520 clocks.
- R4: On lines 6 to 310, `csync_n` is 0 for positions 1 to 15 and 1 for positions 16 to 210.
- R5: On lines 311, 312 and 1 to 5, `csync_n` is 0 at every position.
- R6: `blank` is 1 for positions 1 to 40 of every line.
- R7: `blank` is 1 for the whole of lines 311, 312 and 1 to 23. On lines 24 to 310 it is 0 for positions 41 to 210.
- R8: `eof` is 1 only while the outputs show position 210 of line 312, and the next clock shows position 1 of line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pos | output | 8 | Horizontal position, 1 to 210 |
| line | output | 9 | Line number, 1 to 312 |
| csync_n | output | 1 | Composite sync, low during sync |
| blank | output | 1 | High during line or field blanking |
| eof | output | 1 | High on the last position of the field |

## Verification
The block has no data inputs, so the assertions rely on one thing only: reset is the sole event that can break the regular count. Every property is disabled while `rst_n` is low. The bench exercises this by first running two complete fields without any reset, then pulsing reset at pseudo-random points, including the middle of a line. Each pulse restarts both the expected model and the design from position 1 of line 1.

// File: rtl/cvid_timing_pkg.sv
// Package: default raster geometry shared by the timing block and its parts.
// Assumes positions and lines are numbered from 1, as the pattern logic expects.
package cvid_timing_pkg;
    localparam int DEF_POSITIONS   = 210; // clocks per line
    localparam int DEF_LINES       = 312; // lines per field
    localparam int DEF_HSYNC_LEN   = 15;  // sync-low positions on an active line
    localparam int DEF_HBLANK_LEN  = 40;  // blanked positions at line start
    localparam int DEF_VSYNC_FIRST = 311; // first line of whole-line sync
    localparam int DEF_VSYNC_LAST  = 5;   // last line of whole-line sync (after wrap)
    localparam int DEF_VBLANK_LAST = 23;  // last blanked line at field top
endpackage

// File: rtl/cvid_pos_ctr.sv
// Module: horizontal position counter.
// Counts 1..POSITIONS on every clock and wraps. It exposes the next value so
// that downstream decode can register outputs in step with the count.
// Assumes a synchronous active-low reset that restarts at position 1.
module cvid_pos_ctr #(
    parameter int POSITIONS = cvid_timing_pkg::DEF_POSITIONS,
    parameter int PW        = $clog2(POSITIONS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] pos_q,
    output logic [PW-1:0] pos_d,
    output logic          line_end
);
    localparam logic [PW-1:0] LAST = PW'(POSITIONS);
    localparam logic [PW-1:0] ONE  = PW'(1);

    // Next position: wrap after the last one.
    always_comb begin
        line_end = (pos_q == LAST);
        pos_d    = line_end ? ONE : pos_q + ONE;
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= ONE;
        else        pos_q <= pos_d;
    end

    p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q >= ONE) && (pos_q <= LAST));
    p_pos_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == LAST) |=> (pos_q == ONE));
endmodule

// File: rtl/cvid_line_ctr.sv
// Module: line counter.
// Advances once per line, on the clock after the last position, and wraps
// after the last line of the field. Assumes line_end comes from the
// position counter in the same clock domain.
module cvid_line_ctr #(
    parameter int LINES = cvid_timing_pkg::DEF_LINES,
    parameter int NW    = $clog2(LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    output logic [NW-1:0] line_q,
    output logic [NW-1:0] line_d,
    output logic          field_end
);
    localparam logic [NW-1:0] LAST = NW'(LINES);
    localparam logic [NW-1:0] ONE  = NW'(1);

    // Next line: step only at the end of a line, wrap after the last line.
    always_comb begin
        field_end = line_end && (line_q == LAST);
        if (!line_end)      line_d = line_q;
        else if (field_end) line_d = ONE;
        else                line_d = line_q + ONE;
    end

    // Line register.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= ONE;
        else        line_q <= line_d;
    end

    p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(line_q));
    p_line_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q >= ONE) && (line_q <= LAST));
endmodule

// File: rtl/cvid_sync_decode.sv
// Module: sync, blanking and end-of-field decode.
// Decodes the counters' next values and registers the result, so each
// output changes on the same edge as the counts it describes. Reset values
// match position 1 of line 1.
module cvid_sync_decode #(
    parameter int POSITIONS   = cvid_timing_pkg::DEF_POSITIONS,
    parameter int LINES       = cvid_timing_pkg::DEF_LINES,
    parameter int HSYNC_LEN   = cvid_timing_pkg::DEF_HSYNC_LEN,
    parameter int HBLANK_LEN  = cvid_timing_pkg::DEF_HBLANK_LEN,
    parameter int VSYNC_FIRST = cvid_timing_pkg::DEF_VSYNC_FIRST,
    parameter int VSYNC_LAST  = cvid_timing_pkg::DEF_VSYNC_LAST,
    parameter int VBLANK_LAST = cvid_timing_pkg::DEF_VBLANK_LAST,
    parameter int PW          = $clog2(POSITIONS + 1),
    parameter int NW          = $clog2(LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pos_d,
    input  logic [NW-1:0] line_d,
    output logic          csync_n_q,
    output logic          blank_q,
    output logic          eof_q
);
    localparam logic [PW-1:0] P_LAST   = PW'(POSITIONS);
    localparam logic [PW-1:0] P_HSYNC  = PW'(HSYNC_LEN);
    localparam logic [PW-1:0] P_HBLANK = PW'(HBLANK_LEN);
    localparam logic [NW-1:0] L_LAST   = NW'(LINES);
    localparam logic [NW-1:0] L_VS_LO  = NW'(VSYNC_FIRST);
    localparam logic [NW-1:0] L_VS_HI  = NW'(VSYNC_LAST);
    localparam logic [NW-1:0] L_VB_HI  = NW'(VBLANK_LAST);

    logic vsync_zone, vblank_zone, sync_d, blank_d, eof_d;

    // Decode of the upcoming position and line.
    always_comb begin
        vsync_zone  = (line_d >= L_VS_LO) || (line_d <= L_VS_HI);
        vblank_zone = (line_d >= L_VS_LO) || (line_d <= L_VB_HI);
        sync_d      = !(vsync_zone || (pos_d <= P_HSYNC));
        blank_d     = vblank_zone || (pos_d <= P_HBLANK);
        eof_d       = (pos_d == P_LAST) && (line_d == L_LAST);
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csync_n_q <= 1'b0;
            blank_q   <= 1'b1;
            eof_q     <= 1'b0;
        end else begin
            csync_n_q <= sync_d;
            blank_q   <= blank_d;
            eof_q     <= eof_d;
        end
    end

    p_sync_in_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !csync_n_q |-> blank_q);
    p_eof_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eof_q |=> !eof_q);
endmodule

// File: rtl/cvid_timing.sv
// Module: progressive composite video raster timer (top).
// Ties together the position counter, the line counter and the output
// decode. It has no inputs besides clock and reset, and it free-runs one
// position per clock.
module cvid_timing #(
    parameter int POSITIONS   = cvid_timing_pkg::DEF_POSITIONS,
    parameter int LINES       = cvid_timing_pkg::DEF_LINES,
    parameter int HSYNC_LEN   = cvid_timing_pkg::DEF_HSYNC_LEN,
    parameter int HBLANK_LEN  = cvid_timing_pkg::DEF_HBLANK_LEN,
    parameter int VSYNC_FIRST = cvid_timing_pkg::DEF_VSYNC_FIRST,
    parameter int VSYNC_LAST  = cvid_timing_pkg::DEF_VSYNC_LAST,
    parameter int VBLANK_LAST = cvid_timing_pkg::DEF_VBLANK_LAST,
    localparam int PW         = $clog2(POSITIONS + 1),
    localparam int NW         = $clog2(LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] pos,
    output logic [NW-1:0] line,
    output logic          csync_n,
    output logic          blank,
    output logic          eof
);
    logic [PW-1:0] pos_d;
    logic [NW-1:0] line_d;
    logic          line_end, field_end;

    cvid_pos_ctr #(.POSITIONS(POSITIONS), .PW(PW)) u_pos (
        .clk(clk), .rst_n(rst_n), .pos_q(pos), .pos_d(pos_d), .line_end(line_end));

    cvid_line_ctr #(.LINES(LINES), .NW(NW)) u_line (
        .clk(clk), .rst_n(rst_n), .line_end(line_end),
        .line_q(line), .line_d(line_d), .field_end(field_end));

    cvid_sync_decode #(
        .POSITIONS(POSITIONS), .LINES(LINES), .HSYNC_LEN(HSYNC_LEN),
        .HBLANK_LEN(HBLANK_LEN), .VSYNC_FIRST(VSYNC_FIRST),
        .VSYNC_LAST(VSYNC_LAST), .VBLANK_LAST(VBLANK_LAST), .PW(PW), .NW(NW)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .pos_d(pos_d), .line_d(line_d),
        .csync_n_q(csync_n), .blank_q(blank), .eof_q(eof));

    p_eof_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> (pos == PW'(1)) && (line == NW'(1)));
    p_field_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((line >= NW'(VSYNC_FIRST)) || (line <= NW'(VSYNC_LAST))) |-> !csync_n);
    p_eof_from_ctr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        field_end |-> eof);
endmodule

// File: tb/sim_cvid_timing.sv
// Bench: a behavioural model of position and line, with expected outputs
// computed from the requirements. Two clean fields, then random resets.
module sim_cvid_timing;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pos;
    logic [8:0] line;
    logic       csync_n, blank, eof;

    int n_chk = 0;
    int n_bad = 0;
    int mpos  = 1;
    int mline = 1;

    cvid_timing u0 (.clk(clk), .rst_n(rst_n), .pos(pos), .line(line),
                    .csync_n(csync_n), .blank(blank), .eof(eof));

    always #4 clk = ~clk;

    function automatic bit exp_sync_n(int l, int p);
        if (l >= 311 || l <= 5) return 1'b0;
        return (p > 15);
    endfunction

    function automatic bit exp_blank(int l, int p);
        return (p <= 40) || (l >= 311) || (l <= 23);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (pos %0d line %0d)",
                     req, act, exp, mpos, mline);
        end
    endtask

    // One cycle: compare at the falling edge, then drive reset and step the model.
    task automatic cycle(bit rst_val, bit in_reset);
        @(negedge clk);
        if (in_reset) begin
            chk("R1 pos", int'(pos), 1);
            chk("R1 line", int'(line), 1);
            chk("R1 csync_n", int'(csync_n), 0);
            chk("R1 blank", int'(blank), 1);
            chk("R1 eof", int'(eof), 0);
        end else begin
            chk("R2 pos", int'(pos), mpos);
            chk("R3 line", int'(line), mline);
            if (mline >= 311 || mline <= 5)
                chk("R5 csync_n", int'(csync_n), int'(exp_sync_n(mline, mpos)));
            else
                chk("R4 csync_n", int'(csync_n), int'(exp_sync_n(mline, mpos)));
            if (mpos <= 40)
                chk("R6 blank", int'(blank), int'(exp_blank(mline, mpos)));
            else
                chk("R7 blank", int'(blank), int'(exp_blank(mline, mpos)));
            chk("R8 eof", int'(eof), int'(mpos == 210 && mline == 312));
        end
        rst_n = rst_val;
        if (!rst_val) begin
            mpos = 1; mline = 1;
        end else if (mpos == 210) begin
            mpos = 1;
            mline = (mline == 312) ? 1 : mline + 1;
        end else begin
            mpos++;
        end
    endtask

    initial begin
        #1600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int last_eof;
        int cyc;
        bit was_rst;
        void'($urandom(32'd1997));
        // R1: hold reset for a few edges
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b1);
        // Two whole fields without reset; R3 field length between eof pulses
        last_eof = -1;
        for (int i = 0; i < 2 * 65520 + 400; i++) begin
            cycle(1'b1, 1'b0);
            if (eof) begin
                if (last_eof >= 0) chk("R3 field length", i - last_eof, 65520);
                last_eof = i;
            end
        end
        // Random reset pulses, some mid-line
        was_rst = 1'b0;
        cyc = 0;
        for (int i = 0; i < 15000; i++) begin
            bit r;
            r = ($urandom % 1500) != 0;
            if (i == 7000) r = 1'b0; // directed: reset late in a line window
            cycle(r, was_rst);
            was_rst = !r;
            cyc++;
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule